// File: doc/BRIEF.md
# UART Receive Character Queue

This block is the receive-side storage of a serial port. Each accepted character is stored with its error tags. In queued mode the store is a 16-entry ring. In single mode it is one holding slot. A read strobe from the data register removes the oldest entry and copies that entry's tag bits into a status byte. A status write clears that byte. The block produces the receive-empty and receive-full flags inside an 8-bit flag byte. It also produces one-cycle set and clear pulses for the receive-level interrupt, compared against a programmable trigger level.

A line break arrives on its own strobe and is stored as a tagged entry in the character stream. Any change of the mode bit flushes the store. A push into a store that is already full is refused and reported with a one-cycle overrun pulse. Bit-level deserialisation, the receive timeout and the transmit side sit outside this block.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the flag byte reads 0x90, the status byte reads 0, and `irq_set`, `irq_clr` and `overrun` are low.
- R2: Flag byte layout: bit 7 is transmit-empty and always 1. Bit 6 is receive-full. Bit 5 is transmit-full and always 0. Bit 4 is receive-empty. All other bits read 0.
- R3: With `fifo_en` high, up to 16 entries are kept and read back oldest first. `rd_word` carries the data in bits 7:0 and the tags in bits 10:8. Receive-full is set exactly when 16 entries are held.
- R4: With `fifo_en` low, one entry is kept, and receive-full is set as soon as it is held.
- R5: A push while the store is full (and no pop in the same cycle) is refused. `overrun` is high for the following cycle, and the held contents are unchanged.
- R6: `push_brk` stores the word 0x400 (tag bit 10 set, data zero). When it coincides with `push_valid`, only the break entry is stored.
- R7: `rd_word` always shows the entry at the read position. A pop while empty leaves the position and the flags unchanged.
- R8: Every pop, including one while empty, loads bits 10:8 of the shown word into status bits 2:0. `stat_clr` sets the status byte to 0.
- R9: A change of `fifo_en` empties the store and returns the read position to slot 0. A push or pop in that cycle is ignored.
- R10: `irq_set` pulses for one cycle after a push that makes the count equal to `trig_lvl`. `irq_clr` pulses after a pop that makes the count equal to `trig_lvl` minus one. A cycle with both a push and a pop gives neither pulse.
- R11: The read position wraps from slot 15 to slot 0. A push goes to slot (read position + count) mod 16, so order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Store one received character |
| push_data | input | 8 | Received character |
| push_tags | input | 3 | Error tags stored in bits 10:8 |
| push_brk | input | 1 | Store a break entry (0x400) |
| pop | input | 1 | Data-register read strobe |
| stat_clr | input | 1 | Status-register write strobe |
| fifo_en | input | 1 | 1: 16-entry ring, 0: single slot |
| trig_lvl | input | 5 | Interrupt trigger level in entries |
| rd_word | output | 11 | Entry at the read position |
| flags | output | 8 | Flag byte |
| rx_status | output | 8 | Tags of the last popped entry |
| irq_set | output | 1 | Receive-interrupt set pulse |
| irq_clr | output | 1 | Receive-interrupt clear pulse |
| overrun | output | 1 | Refused-push pulse |

## Verification
On every cycle, the in-line properties check several things. The count never exceeds the capacity of the settled mode. A mode change always leaves an empty store at slot 0. A pop while empty never moves the read position. An overrun pulse only appears with a full store. The flags are never empty and full at once. The interrupt pulses always agree with the trigger level.

Only the bench scenarios can show that data come back in order across the ring wrap, and that a break entry replaces a coincident character. They also show that the status byte holds the tags of the popped word, and that a refused push leaves the stored word untouched.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;
  localparam int WORD_W = DATA_W + TAG_W;
  localparam int BRK_TAG = 2;           // tag bit that marks a line break (word bit 10)

  // Flag byte bit positions.
  localparam int FL_TXE = 7;
  localparam int FL_RXF = 6;
  localparam int FL_TXF = 5;
  localparam int FL_RXE = 4;

  // Ring slot arithmetic.
  function automatic int ring_add(int base, int off, int depth);
    return (base + off) % depth;
  endfunction

  // Capacity for the current mode.
  function automatic int mode_cap(logic queued, int depth);
    return queued ? depth : 1;
  endfunction

  // True when a count step lands on a given level.
  function automatic logic lands_on(int cnt, int step, int lvl);
    return (cnt + step) == lvl;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 11,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_word;
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             fifo_en,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] wr_idx,
  output logic             wr_fire,
  output logic             pop_fire,
  output logic             flush,
  output logic             is_empty,
  output logic             is_full,
  output logic             ovr_o
);
  logic             fifo_q;
  logic [CNT_W-1:0] cap, cap_q;
  logic             ovr_ev;

  assign cap      = CNT_W'(rxq_pkg::mode_cap(fifo_en, DEPTH));
  assign cap_q    = CNT_W'(rxq_pkg::mode_cap(fifo_q, DEPTH));
  assign flush    = fifo_en ^ fifo_q;
  assign is_empty = (count == '0);
  assign is_full  = (count >= cap);
  assign pop_fire = pop_req && !is_empty && !flush;
  assign wr_fire  = push_req && !flush && (!is_full || pop_fire);
  assign ovr_ev   = push_req && !flush && is_full && !pop_fire;
  assign wr_idx   = PTR_W'(rxq_pkg::ring_add(int'(rptr), int'(count), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_q <= 1'b0;
      count  <= '0;
      rptr   <= '0;
      ovr_o  <= 1'b0;
    end else begin
      fifo_q <= fifo_en;
      ovr_o  <= ovr_ev;
      if (flush) begin
        count <= '0;
        rptr  <= '0;
      end else begin
        count <= count + CNT_W'(wr_fire) - CNT_W'(pop_fire);
        if (pop_fire) rptr <= PTR_W'(rxq_pkg::ring_add(int'(rptr), 1, DEPTH));
      end
    end
  end

  // R3
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap_q);
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && (rptr == '0));
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && is_empty && !flush) |=> $stable(rptr));
  // R5
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (count == cap_q));
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int CNT_W = 5,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] trig,
  input  logic             wr_fire,
  input  logic             pop_fire,
  input  logic             pop_req,
  input  logic [TAG_W-1:0] rd_tags,
  input  logic             stat_clr,
  output logic             irq_set_o,
  output logic             irq_clr_o,
  output logic [TAG_W-1:0] stat_o
);
  logic set_ev, clr_ev;

  assign set_ev = wr_fire && !pop_fire && rxq_pkg::lands_on(int'(count), 1, int'(trig));
  assign clr_ev = pop_fire && !wr_fire && rxq_pkg::lands_on(int'(count), -1, int'(trig) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_set_o <= 1'b0;
      irq_clr_o <= 1'b0;
      stat_o    <= '0;
    end else begin
      irq_set_o <= set_ev;
      irq_clr_o <= clr_ev;
      if (pop_req)       stat_o <= rd_tags;
      else if (stat_clr) stat_o <= '0;
    end
  end

  // R10
  set_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |-> (int'(count) == int'($past(trig))));
  // R10
  clr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_o |-> (int'(count) + 1 == int'($past(trig))));
  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !pop_req) |=> (stat_o == '0));
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  logic [rxq_pkg::DATA_W-1:0] push_data,
  input  logic [rxq_pkg::TAG_W-1:0]  push_tags,
  input  logic                       push_brk,
  input  logic                       pop,
  input  logic                       stat_clr,
  input  logic                       fifo_en,
  input  logic [CNT_W-1:0]           trig_lvl,
  output logic [rxq_pkg::WORD_W-1:0] rd_word,
  output logic [7:0]                 flags,
  output logic [7:0]                 rx_status,
  output logic                       irq_set,
  output logic                       irq_clr,
  output logic                       overrun
);
  import rxq_pkg::*;

  localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << (DATA_W + BRK_TAG);

  logic              push_req;
  logic [WORD_W-1:0] push_word;
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  rptr, wr_idx;
  logic              wr_fire, pop_fire, flush, is_empty, is_full;
  logic [TAG_W-1:0]  stat;

  assign push_req  = push_valid || push_brk;
  assign push_word = push_brk ? BRK_WORD : {push_tags, push_data};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop),
    .fifo_en(fifo_en), .count(count), .rptr(rptr), .wr_idx(wr_idx),
    .wr_fire(wr_fire), .pop_fire(pop_fire), .flush(flush),
    .is_empty(is_empty), .is_full(is_full), .ovr_o(overrun)
  );

  rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_idx(wr_idx),
    .wr_word(push_word), .rd_idx(rptr), .rd_word(rd_word)
  );

  rxq_irq #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .count(count), .trig(trig_lvl),
    .wr_fire(wr_fire), .pop_fire(pop_fire), .pop_req(pop),
    .rd_tags(rd_word[WORD_W-1:DATA_W]), .stat_clr(stat_clr),
    .irq_set_o(irq_set), .irq_clr_o(irq_clr), .stat_o(stat)
  );

  always_comb begin
    flags         = '0;
    flags[FL_TXE] = 1'b1;
    flags[FL_TXF] = 1'b0;
    flags[FL_RXF] = is_full;
    flags[FL_RXE] = is_empty;
  end

  assign rx_status = {{(8 - TAG_W){1'b0}}, stat};

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[FL_RXF] && flags[FL_RXE]));
  // R6
  brk_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_brk && wr_fire) |=> (u_store.mem[$past(wr_idx)] == BRK_WORD));
endmodule

// File: tb/rxq_buffer_test.sv
module rxq_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 0, push_brk = 0, pop = 0, stat_clr = 0, fifo_en = 0;
  logic [7:0]  push_data = '0;
  logic [2:0]  push_tags = '0;
  logic [4:0]  trig_lvl = 5'd1;
  logic [10:0] rd_word;
  logic [7:0]  flags, rx_status;
  logic        irq_set, irq_clr, overrun;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  rxq_buffer uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_tags(push_tags), .push_brk(push_brk), .pop(pop), .stat_clr(stat_clr),
    .fifo_en(fifo_en), .trig_lvl(trig_lvl), .rd_word(rd_word), .flags(flags),
    .rx_status(rx_status), .irq_set(irq_set), .irq_clr(irq_clr), .overrun(overrun)
  );

  // op: 1 push, 2 pop; word: pushed word or expected shown word; flags after the step
  localparam logic [20:0] VEC [8] = '{
    {2'd1, 11'h041, 8'h80}, {2'd1, 11'h1C2, 8'h80}, {2'd1, 11'h2A3, 8'h80},
    {2'd2, 11'h041, 8'h80}, {2'd2, 11'h1C2, 8'h80}, {2'd2, 11'h2A3, 8'h90},
    {2'd1, 11'h655, 8'h80}, {2'd2, 11'h655, 8'h90}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One clock step: inputs already driven; sample 2 ns after the edge, then release.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic release_in();
    push_valid = 0; push_brk = 0; pop = 0; stat_clr = 0;
  endtask

  task automatic push_w(logic [10:0] w);
    push_valid = 1; push_tags = w[10:8]; push_data = w[7:0];
    step();
    release_in();
  endtask

  task automatic pop_w();
    pop = 1;
    step();
    release_in();
  endtask

  function automatic logic [10:0] fill_word(int k);
    return {3'(k), 8'(k * 7 + 3)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    fails++; checks++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #25; rst_n = 1'b1;
    #7;
    // R1 reset state
    chk("R1 flags", flags, 8'h90);
    chk("R1 status", rx_status, 0);
    chk("R1 pulses", {irq_set, irq_clr, overrun}, 0);

    // enter queued mode (flush cycle), then walk the table; R3, R2
    @(posedge clk); #2;
    fifo_en = 1; step();
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][20:19] == 2'd1) push_w(VEC[i][18:8]);
      else begin
        chk("R3 order", rd_word, VEC[i][18:8]);
        pop_w();
      end
      chk("R2 flags", flags, VEC[i][7:0]);
    end

    // fill 16 from slot 4, wrapping; R3 R11 R5
    for (int k = 0; k < 16; k++) begin
      push_w(fill_word(k));
      if (k == 14) chk("R3 not full at 15", flags, 8'h80);
    end
    chk("R3 full at 16", flags, 8'hC0);
    push_w(11'h7FF);
    chk("R5 overrun pulse", overrun, 1);
    chk("R5 flags kept", flags, 8'hC0);
    step();
    chk("R5 overrun single cycle", overrun, 0);
    for (int k = 0; k < 16; k++) begin
      chk("R11 wrap order", rd_word, fill_word(k));
      pop_w();
      chk("R8 status from pop", rx_status, k % 8);
    end
    chk("R3 empty after drain", flags, 8'h90);

    // pop while empty; R7 R8
    chk("R7 shown word when empty", rd_word, fill_word(0));
    pop_w();
    chk("R7 word unchanged", rd_word, fill_word(0));
    chk("R7 flags unchanged", flags, 8'h90);
    chk("R8 empty pop loads status", rx_status, 0);

    // break with coincident character; R6 R8
    push_valid = 1; push_brk = 1; push_data = 8'h77; push_tags = 3'd0;
    step(); release_in();
    chk("R6 break word", rd_word, 11'h400);
    chk("R6 one entry", flags, 8'h80);
    pop_w();
    chk("R6 only break stored", flags, 8'h90);
    chk("R8 break tag in status", rx_status, 4);
    stat_clr = 1; step(); release_in();
    chk("R8 status cleared", rx_status, 0);

    // single mode; R9 R4 R5
    fifo_en = 0; step();
    chk("R9 flush flags", flags, 8'h90);
    push_w(11'h012);
    chk("R4 full after one", flags, 8'hC0);
    push_w(11'h034);
    chk("R4 second refused", overrun, 1);
    chk("R5 held word kept", rd_word, 11'h012);
    pop_w();
    chk("R4 empty again", flags, 8'h90);

    // mode change with coincident push; R9
    push_w(11'h0AB);
    chk("R9 held before", flags, 8'hC0);
    fifo_en = 1; push_valid = 1; push_data = 8'hCD; push_tags = 0;
    step(); release_in();
    chk("R9 flushed and push ignored", flags, 8'h90);
    chk("R9 no overrun", overrun, 0);

    // interrupt thresholds with trigger 3; R10
    trig_lvl = 5'd3;
    push_w(11'h001); chk("R10 no set at 1", irq_set, 0);
    push_w(11'h002); chk("R10 no set at 2", irq_set, 0);
    push_w(11'h003); chk("R10 set at 3", irq_set, 1);
    push_w(11'h004); chk("R10 no set at 4", irq_set, 0);
    pop_w(); chk("R10 no clear 4->3", irq_clr, 0);
    pop_w(); chk("R10 clear 3->2", irq_clr, 1);
    pop_w(); chk("R10 no clear 2->1", irq_clr, 0);
    chk("R10 word order", rd_word, 11'h004);
    pop_w();
    chk("R10 drained", flags, 8'h90);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule